// File: doc/BRIEF.md
# Event-Triggered Transfer Controller

This block moves one data unit over a simple memory bus each time an enabled peripheral event fires. It holds a bank of control-data slots. Each slot carries a source address, a destination address, a transfer count, a repeat size and a few mode flags. Each event source owns a group of consecutive slots, and its activation starts at the first slot of that group. A slot whose chain flag is set passes control to the next slot in the same activation, so several transfers can run back to back on one event.

After each transfer the controller updates the slot's addresses and the count, then decides how to hand the event back:

- **Ordinary transfer:** the controller pulses an acknowledge that clears the peripheral's request.
- **Block end:** the controller gives no acknowledge and clears the source's enable bit. The still-pending request then reaches the CPU as an interrupt.
- **Sources marked as no-forward:** these are transmit-empty and flash-ready style sources. They are always acknowledged and never reach the CPU.

Top module: `evt_xfer_ctrl`

## Requirements
- R1: After reset the controller is idle, makes no bus access, all enables (`en_o`) are 0 and all `ack_o` and `irq_o` bits are 0.
- R2: When several enabled sources request at once, the lowest index is serviced first. Each activation, including its whole chain, completes before the next is accepted. `ack_o` is at most one-hot.
- R3: Each transfer reads the slot's source address, then writes the data read to the slot's destination address on the following cycle. Flag bit 0 increments the source address and flag bit 1 increments the destination address after the transfer.
- R4: In normal mode (flag bit 2 = 0) each activation decrements the count. A transfer that takes the count from 1 to 0 is a block end: no `ack_o` pulse, the source's enable bit is cleared, and the request stays pending. Any other transfer pulses `ack_o` for its source.
- R5: In repeat mode (flag bit 2 = 1, flag bit 4 = 0) the repeat-side address always increments. Flag bit 3 = 1 selects the destination as the repeat side. When the count reaches 0 it reloads from the repeat size, the repeat-side address returns to its start value, `ack_o` pulses and the enable stays set.
- R6: In repeat mode with flag bit 4 = 1, the transfer that takes the count to 0 is a block end, as in R4.
- R7: A slot with flag bit 5 set chains to the next slot within the same activation. The block-end decision of a chain uses only the first slot's count; the counts stored in later slots are ignored.
- R8: For sources in `NOIRQ_MASK`, a block end still clears the enable but also pulses `ack_o`, and `irq_o` for that source is never 1.
- R9: No transfer writes to `PROT_ADDR`, the enable register's own address. Such a write is dropped, while the count and acknowledge proceed normally.
- R10: For forwarding sources, `irq_o[i]` is 1 while `evt_i[i]` is 1 and the source's enable is 0. It rises the cycle after a block end clears the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_SRC | Pending request per event source |
| en_we_i | input | 1 | Load the enable vector |
| en_wdata_i | input | NUM_SRC | New enable vector |
| en_o | output | NUM_SRC | Current enable vector |
| irq_o | output | NUM_SRC | Interrupt request forwarded to the CPU |
| cfg_we_i | input | 1 | Write one control-data slot |
| cfg_slot_i | input | SLOT_W | Slot index to write |
| cfg_sa_i | input | ADDR_W | Source address |
| cfg_da_i | input | ADDR_W | Destination address |
| cfg_cnt_i | input | CNT_W | Transfer count |
| cfg_rsize_i | input | CNT_W | Repeat size |
| cfg_flags_i | input | 6 | {chain, rint, rsel_dst, repeat, dinc, sinc} |
| mem_req_o | output | 1 | Bus access request |
| mem_we_o | output | 1 | Bus access is a write |
| mem_addr_o | output | ADDR_W | Bus address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid the cycle after a read request |
| ack_o | output | NUM_SRC | Request-clear pulse to the peripheral |
| busy_o | output | 1 | An activation is in progress |

## Verification
The main function is tried with four distinct patterns:

- **Single-slot normal source:** separates ordinary transfers from the block end through the acknowledge and the interrupt.
- **Two-slot chain with differing stored counts:** shows whether the first slot's count governs.
- **Repeat source run past its reload point:** shows the address restore and the silent continuation, and a one-count repeat slot with the interrupt flag set checks the repeat-mode block end.
- **Simultaneous requests from two sources:** expose the grant order through the order of bus writes.

A transmit-style source, a transfer aimed at the protected address, and a pending request on a disabled source cover the forwarding rules and the write guard.

// File: rtl/evt_xfer_pkg.sv
package evt_xfer_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;
    parameter int CNT_W  = 8;

    typedef struct packed {
        logic [ADDR_W-1:0] sa;
        logic [ADDR_W-1:0] da;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  rsize;
        logic              chain;
        logic              rint;
        logic              rsel_dst;
        logic              rpt;
        logic              dinc;
        logic              sinc;
    } slot_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_WRITE,
        ST_UPDATE,
        ST_FINISH
    } eng_state_t;
endpackage

// File: rtl/xfer_arbiter.sv
module xfer_arbiter #(
    parameter int NUM_SRC = 8,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] req_i,
    output logic               gnt_valid_o,
    output logic [SRC_W-1:0]   gnt_idx_o
);
    logic [NUM_SRC:0]   seen;
    logic [NUM_SRC-1:0] win;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
        assign seen[i+1] = seen[i] | req_i[i];
        assign win[i]    = req_i[i] & ~seen[i];
    end

    always_comb begin
        gnt_idx_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (win[i]) gnt_idx_o = gnt_idx_o | SRC_W'(i);
        end
    end
    assign gnt_valid_o = seen[NUM_SRC];

    // R2: exactly one winner, and it is a requesting source
    assert_one_winner_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt_valid_o |-> ($onehot0(win) && req_i[gnt_idx_o]));
endmodule

// File: rtl/xfer_slot_store.sv
module xfer_slot_store
    import evt_xfer_pkg::*;
#(
    parameter int NUM_SLOT = 24,
    localparam int SLOT_W  = $clog2(NUM_SLOT)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [SLOT_W-1:0] cfg_idx_i,
    input  slot_t             cfg_slot_i,
    input  logic              wb_we_i,
    input  logic [SLOT_W-1:0] wb_idx_i,
    input  slot_t             wb_slot_i,
    input  logic [SLOT_W-1:0] rd_idx_i,
    output slot_t             rd_slot_o
);
    slot_t bank_d [NUM_SLOT];
    slot_t bank_q [NUM_SLOT];

    always_comb begin
        bank_d = bank_q;
        if (cfg_we_i && (int'(cfg_idx_i) < NUM_SLOT)) bank_d[cfg_idx_i] = cfg_slot_i;
        if (wb_we_i && (int'(wb_idx_i) < NUM_SLOT))   bank_d[wb_idx_i]  = wb_slot_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < NUM_SLOT; i++) bank_q[i] <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_slot_o = (int'(rd_idx_i) < NUM_SLOT) ? bank_q[rd_idx_i] : '0;
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
    import evt_xfer_pkg::*;
#(
    parameter int                  NUM_SRC    = 8,
    parameter int                  NUM_SLOT   = 24,
    parameter logic [NUM_SRC-1:0]  NOIRQ_MASK = 8'h80,
    parameter logic [ADDR_W-1:0]   PROT_ADDR  = 16'h00F0,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int SLOT_W = $clog2(NUM_SLOT),
    localparam int SPS    = NUM_SLOT / NUM_SRC
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               gnt_valid_i,
    input  logic [SRC_W-1:0]   gnt_idx_i,
    output logic [SLOT_W-1:0]  rd_idx_o,
    input  slot_t              rd_slot_i,
    output logic               wb_we_o,
    output logic [SLOT_W-1:0]  wb_idx_o,
    output slot_t              wb_slot_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [DATA_W-1:0]  mem_wdata_o,
    input  logic [DATA_W-1:0]  mem_rdata_i,
    output logic [NUM_SRC-1:0] ack_o,
    output logic [NUM_SRC-1:0] en_clr_o,
    output logic               busy_o,
    output logic [SRC_W-1:0]   busy_src_o
);
    typedef struct packed {
        eng_state_t        st;
        logic [SRC_W-1:0]  src;
        logic [SLOT_W-1:0] slot;
        slot_t             cur;
        logic              first;
        logic [CNT_W-1:0]  cnt;
        logic              zero;
        logic              blk;
    } eng_regs_t;

    eng_regs_t r_d, r_q;

    logic [CNT_W-1:0]  cnt_dec;
    logic              zero_now;
    logic              zero_use;
    logic              rep_src;
    logic              rep_dst;
    logic [ADDR_W-1:0] sa_n;
    logic [ADDR_W-1:0] da_n;

    always_comb begin
        r_d         = r_q;
        wb_we_o     = 1'b0;
        wb_idx_o    = r_q.slot;
        wb_slot_o   = r_q.cur;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        ack_o       = '0;
        en_clr_o    = '0;
        cnt_dec     = r_q.cur.cnt - CNT_W'(1);
        zero_now    = (cnt_dec == '0);
        zero_use    = r_q.first ? zero_now : r_q.zero;
        rep_src     = r_q.cur.rpt & ~r_q.cur.rsel_dst;
        rep_dst     = r_q.cur.rpt & r_q.cur.rsel_dst;
        sa_n        = r_q.cur.sa;
        da_n        = r_q.cur.da;

        case (r_q.st)
            ST_IDLE: begin
                if (gnt_valid_i) begin
                    r_d.src   = gnt_idx_i;
                    r_d.slot  = SLOT_W'(gnt_idx_i) * SLOT_W'(SPS);
                    r_d.first = 1'b1;
                    r_d.blk   = 1'b0;
                    r_d.zero  = 1'b0;
                    r_d.st    = ST_FETCH;
                end
            end
            ST_FETCH: begin
                r_d.cur = rd_slot_i;
                r_d.st  = ST_READ;
            end
            ST_READ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.cur.sa;
                r_d.st     = ST_WRITE;
            end
            ST_WRITE: begin
                if (r_q.cur.da != PROT_ADDR) begin
                    mem_req_o   = 1'b1;
                    mem_we_o    = 1'b1;
                    mem_addr_o  = r_q.cur.da;
                    mem_wdata_o = mem_rdata_i;
                end
                r_d.st = ST_UPDATE;
            end
            ST_UPDATE: begin
                if (r_q.first) begin
                    r_d.zero = zero_now;
                    r_d.blk  = r_q.cur.rpt ? (zero_now & r_q.cur.rint) : zero_now;
                    r_d.cnt  = (r_q.cur.rpt && zero_now) ? r_q.cur.rsize : cnt_dec;
                end
                if (r_q.cur.sinc || rep_src) sa_n = r_q.cur.sa + ADDR_W'(1);
                if (r_q.cur.dinc || rep_dst) da_n = r_q.cur.da + ADDR_W'(1);
                if (rep_src && zero_use) sa_n = r_q.cur.sa + ADDR_W'(1) - ADDR_W'(r_q.cur.rsize);
                if (rep_dst && zero_use) da_n = r_q.cur.da + ADDR_W'(1) - ADDR_W'(r_q.cur.rsize);
                wb_we_o       = 1'b1;
                wb_slot_o.sa  = sa_n;
                wb_slot_o.da  = da_n;
                wb_slot_o.cnt = r_d.cnt;
                if (r_q.cur.chain && (int'(r_q.slot) < NUM_SLOT - 1)) begin
                    r_d.slot  = r_q.slot + SLOT_W'(1);
                    r_d.first = 1'b0;
                    r_d.st    = ST_FETCH;
                end else begin
                    r_d.st = ST_FINISH;
                end
            end
            ST_FINISH: begin
                if (r_q.blk) en_clr_o[r_q.src] = 1'b1;
                if (!r_q.blk || NOIRQ_MASK[r_q.src]) ack_o[r_q.src] = 1'b1;
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_idx_o   = r_q.slot;
    assign busy_o     = (r_q.st != ST_IDLE);
    assign busy_src_o = r_q.src;

    assert_write_after_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_we_o) |-> $past(mem_req_o && !mem_we_o));
    assert_no_protected_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_we_o) |-> (mem_addr_o != PROT_ADDR));
    assert_single_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(ack_o));
    assert_blockend_keeps_request_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((en_clr_o & ack_o & ~NOIRQ_MASK) == '0));
endmodule

// File: rtl/evt_xfer_ctrl.sv
module evt_xfer_ctrl
    import evt_xfer_pkg::*;
#(
    parameter int                 NUM_SRC    = 8,
    parameter int                 NUM_SLOT   = 24,
    parameter logic [NUM_SRC-1:0] NOIRQ_MASK = 8'h80,
    parameter logic [ADDR_W-1:0]  PROT_ADDR  = 16'h00F0,
    localparam int SLOT_W = $clog2(NUM_SLOT),
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               en_we_i,
    input  logic [NUM_SRC-1:0] en_wdata_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] irq_o,
    input  logic               cfg_we_i,
    input  logic [SLOT_W-1:0]  cfg_slot_i,
    input  logic [ADDR_W-1:0]  cfg_sa_i,
    input  logic [ADDR_W-1:0]  cfg_da_i,
    input  logic [CNT_W-1:0]   cfg_cnt_i,
    input  logic [CNT_W-1:0]   cfg_rsize_i,
    input  logic [5:0]         cfg_flags_i,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [DATA_W-1:0]  mem_wdata_o,
    input  logic [DATA_W-1:0]  mem_rdata_i,
    output logic [NUM_SRC-1:0] ack_o,
    output logic               busy_o
);
    logic [NUM_SRC-1:0] en_d, en_q;
    logic [NUM_SRC-1:0] en_clr;
    logic [NUM_SRC-1:0] busy_mask;
    logic               gnt_valid;
    logic [SRC_W-1:0]   gnt_idx;
    logic [SRC_W-1:0]   busy_src;
    logic [SLOT_W-1:0]  rd_idx;
    slot_t              rd_slot;
    logic               wb_we;
    logic [SLOT_W-1:0]  wb_idx;
    slot_t              wb_slot;
    slot_t              cfg_slot;

    assign cfg_slot = '{sa: cfg_sa_i, da: cfg_da_i, cnt: cfg_cnt_i, rsize: cfg_rsize_i,
                        chain: cfg_flags_i[5], rint: cfg_flags_i[4], rsel_dst: cfg_flags_i[3],
                        rpt: cfg_flags_i[2], dinc: cfg_flags_i[1], sinc: cfg_flags_i[0]};

    xfer_arbiter #(.NUM_SRC(NUM_SRC)) arb_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_i       (evt_i & en_q),
        .gnt_valid_o (gnt_valid),
        .gnt_idx_o   (gnt_idx)
    );

    xfer_slot_store #(.NUM_SLOT(NUM_SLOT)) store_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cfg_we_i   (cfg_we_i),
        .cfg_idx_i  (cfg_slot_i),
        .cfg_slot_i (cfg_slot),
        .wb_we_i    (wb_we),
        .wb_idx_i   (wb_idx),
        .wb_slot_i  (wb_slot),
        .rd_idx_i   (rd_idx),
        .rd_slot_o  (rd_slot)
    );

    xfer_engine #(
        .NUM_SRC    (NUM_SRC),
        .NUM_SLOT   (NUM_SLOT),
        .NOIRQ_MASK (NOIRQ_MASK),
        .PROT_ADDR  (PROT_ADDR)
    ) eng_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .gnt_valid_i (gnt_valid),
        .gnt_idx_i   (gnt_idx),
        .rd_idx_o    (rd_idx),
        .rd_slot_i   (rd_slot),
        .wb_we_o     (wb_we),
        .wb_idx_o    (wb_idx),
        .wb_slot_o   (wb_slot),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i),
        .ack_o       (ack_o),
        .en_clr_o    (en_clr),
        .busy_o      (busy_o),
        .busy_src_o  (busy_src)
    );

    always_comb begin
        en_d = en_we_i ? en_wdata_i : en_q;
        en_d = en_d & ~en_clr;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) en_q <= '0;
        else         en_q <= en_d;
    end

    always_comb begin
        busy_mask = '0;
        if (busy_o) busy_mask[busy_src] = 1'b1;
    end

    assign irq_o = evt_i & ~en_q & ~NOIRQ_MASK & ~busy_mask;
    assign en_o  = en_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_irq_chk
        if (NOIRQ_MASK[i]) begin : g_silent
            assert_silent_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                en_clr[i] |=> !irq_o[i]);
        end else begin : g_fwd
            assert_irq_after_blockend_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (en_clr[i] && evt_i[i] && !en_we_i) |=> (irq_o[i] || !evt_i[i]));
        end
    end
endmodule

// File: tb/evt_xfer_ctrl_tb_top.sv
module evt_xfer_ctrl_tb_top;
    localparam logic [15:0] PROT = 16'h00F0;

    typedef struct {
        logic [15:0] a;
        logic [7:0]  d;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  flag_q;
    logic [7:0]  set_v = '0;
    logic [7:0]  clr_v = '0;
    logic        en_we = 1'b0;
    logic [7:0]  en_wdata = '0;
    logic [7:0]  en_o, irq_o, ack_o;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_slot = '0;
    logic [15:0] cfg_sa = '0, cfg_da = '0;
    logic [7:0]  cfg_cnt = '0, cfg_rsize = '0;
    logic [5:0]  cfg_flags = '0;
    logic        mem_req, mem_we, busy;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    int          n_chk = 0;
    int          n_fail = 0;
    exp_t        sb_q[$];
    exp_t        mon_e;

    always #5 clk = ~clk;

    evt_xfer_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(flag_q), .en_we_i(en_we), .en_wdata_i(en_wdata),
        .en_o(en_o), .irq_o(irq_o), .cfg_we_i(cfg_we), .cfg_slot_i(cfg_slot),
        .cfg_sa_i(cfg_sa), .cfg_da_i(cfg_da), .cfg_cnt_i(cfg_cnt), .cfg_rsize_i(cfg_rsize),
        .cfg_flags_i(cfg_flags), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .ack_o(ack_o), .busy_o(busy)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    // peripheral request flags and read-only memory model
    always @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q | set_v) & ~(ack_o | clr_v);
        if (mem_req && !mem_we) mem_rdata <= pat(mem_addr);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_we) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R3/R9 unexpected write", int'(mem_addr), 0);
            end else begin
                mon_e = sb_q.pop_front();
                check(mem_addr == mon_e.a, "R3 write address", int'(mem_addr), int'(mon_e.a));
                check(mem_wdata == mon_e.d, "R3 write data", int'(mem_wdata), int'(mon_e.d));
            end
        end
    end

    task automatic push(input logic [15:0] a, input logic [15:0] src);
        exp_t e;
        e.a = a;
        e.d = pat(src);
        sb_q.push_back(e);
    endtask

    task automatic cfg(input int s, input logic [15:0] sa, input logic [15:0] da,
                       input logic [7:0] cnt, input logic [7:0] rs, input logic [5:0] fl);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = 5'(s); cfg_sa = sa; cfg_da = da;
        cfg_cnt = cnt; cfg_rsize = rs; cfg_flags = fl;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_en(input logic [7:0] v);
        @(negedge clk);
        en_we = 1'b1; en_wdata = v;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    task automatic fire(input logic [7:0] v);
        @(negedge clk);
        set_v = v;
        @(negedge clk);
        set_v = '0;
        repeat (24) @(negedge clk);
    endtask

    task automatic clear(input logic [7:0] v);
        @(negedge clk);
        clr_v = v;
        @(negedge clk);
        clr_v = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(en_o == 8'h00, "R1 enables", en_o, 0);
        check(irq_o == 8'h00, "R1 irq", irq_o, 0);
        check(ack_o == 8'h00, "R1 ack", ack_o, 0);
        check(!busy && !mem_req, "R1 idle", {busy, mem_req}, 0);

        // R10: pending request on a disabled forwarding source goes to the CPU
        fire(8'h02);
        check(irq_o[1] == 1'b1, "R10 disabled pending forwards", irq_o, 8'h02);
        check(flag_q[1] == 1'b1, "R10 not serviced", flag_q, 8'h02);
        clear(8'h02);

        // R4: normal mode, count 2
        cfg(0, 16'h0010, 16'h0080, 8'd2, 8'd0, 6'b000011);
        set_en(8'h01);
        push(16'h0080, 16'h0010);
        fire(8'h01);
        check(flag_q[0] == 1'b0, "R4 ack clears request", flag_q, 0);
        check(en_o[0] == 1'b1, "R4 enable kept", en_o, 1);
        push(16'h0081, 16'h0011);
        fire(8'h01);
        check(flag_q[0] == 1'b1, "R4 block end keeps request", flag_q, 1);
        check(en_o[0] == 1'b0, "R4 enable cleared", en_o, 0);
        check(irq_o[0] == 1'b1, "R10 irq after block end", irq_o, 1);
        clear(8'h01);

        // R7: chain, first count 2, second slot stores 9
        cfg(3, 16'h0060, 16'h00D0, 8'd2, 8'd0, 6'b100011);
        cfg(4, 16'h0068, 16'h00D8, 8'd9, 8'd0, 6'b000011);
        set_en(8'h02);
        push(16'h00D0, 16'h0060);
        push(16'h00D8, 16'h0068);
        fire(8'h02);
        check(flag_q[1] == 1'b0 && en_o[1], "R7 chain first pass acked", {flag_q[1], en_o[1]}, 1);
        push(16'h00D1, 16'h0061);
        push(16'h00D9, 16'h0069);
        fire(8'h02);
        check(en_o[1] == 1'b0, "R7 chain ends on first count", en_o, 0);
        check(irq_o[1] == 1'b1, "R7 chain block end irq", irq_o, 2);
        clear(8'h02);

        // R5: repeat on destination, size 2, no interrupt flag
        cfg(6, 16'h0040, 16'h0090, 8'd2, 8'd2, 6'b001100);
        set_en(8'h04);
        push(16'h0090, 16'h0040);
        fire(8'h04);
        push(16'h0091, 16'h0040);
        fire(8'h04);
        push(16'h0090, 16'h0040);
        fire(8'h04);
        check(en_o[2] == 1'b1, "R5 repeat keeps enable", en_o, 4);
        check(flag_q[2] == 1'b0 && irq_o[2] == 1'b0, "R5 repeat acked", {flag_q[2], irq_o[2]}, 0);

        // R6: repeat with interrupt flag, count 1
        cfg(9, 16'h0020, 16'h00B0, 8'd1, 8'd1, 6'b011110);
        set_en(8'h0C);
        push(16'h00B0, 16'h0020);
        fire(8'h08);
        check(en_o[3] == 1'b0 && flag_q[3] == 1'b1, "R6 repeat block end", {en_o[3], flag_q[3]}, 2'b01);
        check(irq_o[3] == 1'b1, "R6 irq", irq_o, 8);
        clear(8'h08);

        // R2: sources 4 and 5 together, lowest first
        cfg(12, 16'h0050, 16'h00A0, 8'd5, 8'd0, 6'b000011);
        cfg(15, 16'h0058, 16'h00A8, 8'd5, 8'd0, 6'b000011);
        set_en(8'h30);
        push(16'h00A0, 16'h0050);
        push(16'h00A8, 16'h0058);
        fire(8'h30);
        check(flag_q[5:4] == 2'b00, "R2 both serviced", flag_q, 0);

        // R8: no-forward source 7, count 1
        cfg(21, 16'h0070, 16'h00C0, 8'd1, 8'd0, 6'b000011);
        set_en(8'h80);
        push(16'h00C0, 16'h0070);
        fire(8'h80);
        check(en_o[7] == 1'b0, "R8 enable cleared", en_o, 0);
        check(flag_q[7] == 1'b0, "R8 acked at block end", flag_q, 0);
        check(irq_o[7] == 1'b0, "R8 no irq", irq_o, 0);

        // R9: write to the protected address is dropped
        cfg(18, 16'h0030, PROT, 8'd3, 8'd0, 6'b000001);
        set_en(8'h40);
        fire(8'h40);
        check(flag_q[6] == 1'b0 && en_o[6], "R9 transfer still acked", {flag_q[6], en_o[6]}, 1);

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R3 all expected writes seen", sb_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule